// File: doc/BRIEF.md
# Tachometer Speed Lock Monitor

This block judges whether a motor runs at its commanded speed. It measures the time between rising edges of a digitized tachometer pulse train in units of a reference clock enable, and compares that count with a nominal count. The nominal count comes from a small pre-divider table times a base divide. A count within ±5% of nominal sets the lock flag, which is active low. A count short by more than 5% (the motor is too fast) sets an overspeed flag, and that flag holds until the motor has slowed below the nominal speed.

Two timers guard against a stalled motor. A missing-pulse watchdog counts PWM-rate ticks and is cleared by every tachometer transition. When it expires it requests full "up" drive and drops lock. A stall timer counts slow lock-timer ticks while the motor is out of lock and sends a single time-out pulse to the shutdown logic when it reaches its limit. The stop level of the start/stop input clears the stall timer.

Top module: `speed_lock_monitor`

## Requirements
- R1: The pre-divider is 3, 4, 6 or 8 for `cfg_div` = 00, 01, 10 or 11 when `freq_sel` = 1, and twice that when `freq_sel` = 0. The nominal count N is the pre-divider times BASE_DIV (default 1024).
- R2: The measured count M is the number of cycles with `ref_en` high after one tachometer rising edge, up to the cycle before the next. M saturates at 64·BASE_DIV−1. On an edge, lock is declared when ceil(0.95·N) ≤ M ≤ floor(1.05·N) and withdrawn otherwise. `lock_n` is 0 while locked and 1 while not locked.
- R3: The first rising edge after reset or after a watchdog expiry only starts a measurement and never sets lock.
- R4: The tachometer input passes through two synchronizer flops. A lock decision is visible on `lock_n` at the third rising clock edge, counting the first edge that samples the new tachometer level.
- R5: `overspeed` is set by an edge decision with M < ceil(0.95·N) and cleared by one with M > N. Any other decision leaves it unchanged. A watchdog expiry clears it.
- R6: The watchdog counts `pwm_tick` pulses and is cleared by every synchronized tachometer transition, rising or falling. On the WD_LIMIT-th tick (default 512), `force_up` goes to 1 and lock is dropped. `force_up` returns to 0 after the next transition.
- R7: While not locked and not stopped, the stall counter advances once per `lt_tick`. When it reaches LT_LIMIT (default 1023), `stall_timeout` is high for exactly one cycle. The counter then holds, so no further pulse follows.
- R8: `start_stop` = 1 (stop), a held reset, or being locked clears the stall counter. After a clear, a full LT_LIMIT ticks are needed before the next time-out.
- R9: While `rst_n` is low at a clock edge, every register is cleared: `lock_n` = 1, and `overspeed`, `force_up` and `stall_timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en | input | 1 | Reference clock enable, one pulse per crystal period |
| tach_in | input | 1 | Asynchronous digitized tachometer signal |
| lt_tick | input | 1 | Slow lock-timer tick, one cycle wide |
| pwm_tick | input | 1 | PWM-rate tick, one cycle wide |
| start_stop | input | 1 | 1 = stop (clears stall timer), 0 = run |
| cfg_div | input | 2 | Pre-divider select |
| freq_sel | input | 1 | 1 = base pre-divider, 0 = doubled |
| lock_n | output | 1 | Active-low speed lock |
| overspeed | output | 1 | Coast request, motor too fast |
| force_up | output | 1 | Watchdog request for full up drive |
| stall_timeout | output | 1 | One-cycle time-out to shutdown logic |

## Verification
All outputs are registers. A tachometer level change reaches `lock_n` and `overspeed` three edges after it is first sampled: two synchronizer flops, then the decision register. `force_up` follows the expiring tick at the next edge. `stall_timeout` rises at the edge that samples the LT_LIMIT-th tick. The bench keeps a behavioural model that advances on the same edges from the same inputs. It compares all four outputs on every falling edge, so a result that comes early or late by a single cycle is reported.

// File: rtl/slk_pkg.sv
// Shared helpers for the speed lock monitor: pre-divider table and window bounds.
// Assumes nominal counts fit comfortably in 32 bits.
package slk_pkg;

    // Pre-divider for a configuration code; the select pin low doubles it.
    function automatic logic [4:0] pre_div(input logic [1:0] sel, input logic fsel);
        logic [4:0] base;
        case (sel)
            2'b00:   base = 5'd3;
            2'b01:   base = 5'd4;
            2'b10:   base = 5'd6;
            default: base = 5'd8;
        endcase
        return fsel ? base : (base << 1);
    endfunction

    // Lower window bound: 95 % of nominal, rounded up (toward the inside).
    function automatic logic [31:0] win_lo(input logic [31:0] nom);
        return (nom * 32'd95 + 32'd99) / 32'd100;
    endfunction

    // Upper window bound: 105 % of nominal, rounded down (toward the inside).
    function automatic logic [31:0] win_hi(input logic [31:0] nom);
        return (nom * 32'd105) / 32'd100;
    endfunction

endpackage

// File: rtl/slk_tach_sync.sv
// Synchronizes the tachometer input and flags its rising edge and any transition.
// Assumes tach_in is asynchronous and slow relative to clk.
module slk_tach_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_in,
    output logic rise,
    output logic toggle
);
    localparam int LEN = SYNC_STAGES + 1;

    logic [LEN-1:0] shreg;

    // Shift the raw input through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[LEN-2:0], tach_in};
    end

    assign rise   = shreg[LEN-2] & ~shreg[LEN-1];
    assign toggle = shreg[LEN-2] ^ shreg[LEN-1];

endmodule

// File: rtl/slk_watchdog.sv
// Missing-pulse watchdog: counts PWM ticks between tachometer transitions.
// Assumes pwm_tick is a single-cycle pulse; toggle has priority over a tick.
module slk_watchdog #(
    parameter int WD_LIMIT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    input  logic pwm_tick,
    output logic expired
);
    localparam int WD_W = $clog2(WD_LIMIT + 1);

    logic [WD_W-1:0] wcnt;

    // Count ticks, expire on the limit-th one, restart on every transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt    <= '0;
            expired <= 1'b0;
        end else if (toggle) begin
            wcnt    <= '0;
            expired <= 1'b0;
        end else if (pwm_tick && !expired) begin
            if (wcnt == WD_W'(WD_LIMIT - 1)) begin
                expired <= 1'b1;
                wcnt    <= '0;
            end else begin
                wcnt <= wcnt + 1'b1;
            end
        end
    end

    a_r6_expire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(pwm_tick));
    a_r6_clear_on_transition: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(expired) |-> $past(toggle));

endmodule

// File: rtl/slk_period_meter.sv
// Measures reference pulses per tachometer period and makes lock/overspeed decisions.
// Assumes win_lo <= nominal <= win_hi and that they stay stable within a period.
module slk_period_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             rise,
    input  logic             wd_expired,
    input  logic [CNT_W-1:0] nominal,
    input  logic [CNT_W-1:0] bound_lo,
    input  logic [CNT_W-1:0] bound_hi,
    output logic             locked,
    output logic             overspeed
);
    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             in_win;
    logic             too_fast;
    logic             below_nom;

    assign in_win    = (cnt >= bound_lo) && (cnt <= bound_hi);
    assign too_fast  = cnt < bound_lo;
    assign below_nom = cnt > nominal;

    // Saturating count of reference enables since the last rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (rise)                cnt <= '0;
        else if (ref_en && cnt != '1) cnt <= cnt + 1'b1;
    end

    // Decide lock and overspeed on each armed edge; drop both on watchdog expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            locked    <= 1'b0;
            overspeed <= 1'b0;
        end else if (rise) begin
            armed <= 1'b1;
            if (wd_expired) begin
                locked    <= 1'b0;
                overspeed <= 1'b0;
            end else if (armed) begin
                locked <= in_win;
                if (too_fast)       overspeed <= 1'b1;
                else if (below_nom) overspeed <= 1'b0;
            end
        end else if (wd_expired) begin
            armed     <= 1'b0;
            locked    <= 1'b0;
            overspeed <= 1'b0;
        end
    end

    a_r3_lock_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(rise) && !$past(wd_expired));
    a_r5_overspeed_means_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overspeed) |-> !locked);
    a_r5_overspeed_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overspeed) |-> ($past(rise) || $past(wd_expired)));

endmodule

// File: rtl/slk_stall_timer.sv
// Stall timer: counts slow ticks while out of lock and pulses a time-out once.
// Assumes lt_tick is a single-cycle pulse.
module slk_stall_timer #(
    parameter int LT_LIMIT = 1023
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lt_tick,
    input  logic locked,
    input  logic start_stop,
    output logic timeout
);
    localparam int LT_W = $clog2(LT_LIMIT + 1);

    logic [LT_W-1:0] lt_cnt;
    logic            at_last;

    assign at_last = (lt_cnt == LT_W'(LT_LIMIT - 1));

    // Advance while unlocked and running; hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || start_stop || locked)                 lt_cnt <= '0;
        else if (lt_tick && lt_cnt != LT_W'(LT_LIMIT))      lt_cnt <= lt_cnt + 1'b1;
    end

    // One-cycle pulse on the tick that reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) timeout <= 1'b0;
        else        timeout <= !start_stop && !locked && lt_tick && at_last;
    end

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);
    a_r7_pulse_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> lt_cnt == LT_W'(LT_LIMIT));
    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_stop |=> lt_cnt == '0);

endmodule

// File: rtl/speed_lock_monitor.sv
// Top: tachometer speed lock detector with missing-pulse watchdog and stall timer.
// Assumes all tick inputs are single-cycle pulses synchronous to clk.
module speed_lock_monitor #(
    parameter int BASE_DIV = 1024,
    parameter int WD_LIMIT = 512,
    parameter int LT_LIMIT = 1023
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_en,
    input  logic       tach_in,
    input  logic       lt_tick,
    input  logic       pwm_tick,
    input  logic       start_stop,
    input  logic [1:0] cfg_div,
    input  logic       freq_sel,
    output logic       lock_n,
    output logic       overspeed,
    output logic       force_up,
    output logic       stall_timeout
);
    localparam int CNT_W = $clog2(BASE_DIV) + 6;

    logic             rise;
    logic             toggle;
    logic             wd_expired;
    logic             locked;
    logic [31:0]      nom32;
    logic [CNT_W-1:0] nominal;
    logic [CNT_W-1:0] bound_lo;
    logic [CNT_W-1:0] bound_hi;

    // Nominal count and inward-rounded window from the configuration.
    assign nom32    = 32'(slk_pkg::pre_div(cfg_div, freq_sel)) * 32'(BASE_DIV);
    assign nominal  = CNT_W'(nom32);
    assign bound_lo = CNT_W'(slk_pkg::win_lo(nom32));
    assign bound_hi = CNT_W'(slk_pkg::win_hi(nom32));

    slk_tach_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .rise(rise), .toggle(toggle)
    );

    slk_watchdog #(.WD_LIMIT(WD_LIMIT)) u_wd (
        .clk(clk), .rst_n(rst_n), .toggle(toggle), .pwm_tick(pwm_tick), .expired(wd_expired)
    );

    slk_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .rise(rise), .wd_expired(wd_expired),
        .nominal(nominal), .bound_lo(bound_lo), .bound_hi(bound_hi),
        .locked(locked), .overspeed(overspeed)
    );

    slk_stall_timer #(.LT_LIMIT(LT_LIMIT)) u_stall (
        .clk(clk), .rst_n(rst_n), .lt_tick(lt_tick), .locked(locked),
        .start_stop(start_stop), .timeout(stall_timeout)
    );

    assign lock_n   = ~locked;
    assign force_up = wd_expired;

    a_r2_lock_excludes_watchdog: assert property (@(posedge clk) disable iff (!rst_n)
        force_up |=> lock_n);

endmodule

// File: tb/speed_lock_monitor_test.sv
module speed_lock_monitor_test;
    localparam int BD   = 64;
    localparam int WDL  = 80;
    localparam int LTL  = 40;
    localparam int CMAX = 64 * BD - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_en = 1'b1;
    logic       tach_in = 1'b0;
    logic       lt_tick = 1'b0;
    logic       pwm_tick = 1'b0;
    logic       start_stop = 1'b0;
    logic [1:0] cfg_div = 2'b00;
    logic       freq_sel = 1'b1;
    logic       lock_n, overspeed, force_up, stall_timeout;

    int checks = 0;
    int fails = 0;
    int ref_half = 0;
    int to_seen = 0;
    bit done = 0;

    speed_lock_monitor #(.BASE_DIV(BD), .WD_LIMIT(WDL), .LT_LIMIT(LTL)) uut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .tach_in(tach_in), .lt_tick(lt_tick),
        .pwm_tick(pwm_tick), .start_stop(start_stop), .cfg_div(cfg_div), .freq_sel(freq_sel),
        .lock_n(lock_n), .overspeed(overspeed), .force_up(force_up), .stall_timeout(stall_timeout)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_pre(input int sel, input int fs);
        int b;
        b = (sel == 0) ? 3 : (sel == 1) ? 4 : (sel == 2) ? 6 : 8;
        return fs ? b : 2 * b;
    endfunction

    // Behavioural reference model state
    int q_tach[$];
    int m_prev = 0, m_wc = 0, m_exp = 0, m_cnt = 0, m_armed = 0;
    int m_lock = 0, m_ovs = 0, m_lt = 0, m_to = 0;
    int n, lo, hi, rise_i, tog_i, old_exp, old_lock, cur;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_tach = {0, 0};
            m_prev = 0; m_wc = 0; m_exp = 0; m_cnt = 0; m_armed = 0;
            m_lock = 0; m_ovs = 0; m_lt = 0; m_to = 0;
        end else begin
            cur    = q_tach[1];
            rise_i = (cur == 1 && m_prev == 0);
            tog_i  = (cur != m_prev);
            old_exp  = m_exp;
            old_lock = m_lock;
            n  = model_pre(cfg_div, freq_sel) * BD;
            lo = (95 * n) / 100 + (((95 * n) % 100) != 0 ? 1 : 0);
            hi = (105 * n) / 100;
            if (tog_i) begin m_wc = 0; m_exp = 0; end
            else if (pwm_tick && !m_exp) begin
                m_wc++;
                if (m_wc == WDL) begin m_exp = 1; m_wc = 0; end
            end
            m_to = (!start_stop && !old_lock && lt_tick && m_lt == LTL - 1) ? 1 : 0;
            if (start_stop || old_lock) m_lt = 0;
            else if (lt_tick && m_lt < LTL) m_lt++;
            if (rise_i) begin
                if (old_exp) begin m_lock = 0; m_ovs = 0; end
                else if (m_armed) begin
                    m_lock = (m_cnt >= lo && m_cnt <= hi) ? 1 : 0;
                    if (m_cnt < lo) m_ovs = 1;
                    else if (m_cnt > n) m_ovs = 0;
                end
                m_armed = 1;
            end else if (old_exp) begin
                m_armed = 0; m_lock = 0; m_ovs = 0;
            end
            if (rise_i) m_cnt = 0;
            else if (ref_en && m_cnt < CMAX) m_cnt++;
            m_prev = cur;
            q_tach.push_front(int'(tach_in));
            void'(q_tach.pop_back());
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (!done) begin
            chk("R2 R4 lock_n", int'(lock_n), m_lock ? 0 : 1);
            chk("R5 overspeed", int'(overspeed), m_ovs);
            chk("R6 force_up", int'(force_up), m_exp);
            chk("R7 stall_timeout", int'(stall_timeout), m_to);
            if (stall_timeout) to_seen++;
        end
    end

    // Tick generators and reference enable pattern.
    initial begin
        for (int cyc = 0; ; cyc++) begin
            @(negedge clk);
            pwm_tick = (cyc % 8) == 0;
            lt_tick  = (cyc % 32) == 0;
            ref_en   = ref_half ? ((cyc % 2) == 0) : 1'b1;
        end
    end

    task automatic tach_periods(input int p, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            tach_in = 1'b1;
            repeat (p / 2) @(negedge clk);
            tach_in = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R9: reset state
        chk("R9 lock_n reset", int'(lock_n), 1);
        chk("R9 overspeed reset", int'(overspeed), 0);
        chk("R9 force_up reset", int'(force_up), 0);
        chk("R9 stall_timeout reset", int'(stall_timeout), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3: first edge only arms; still unlocked before the second edge
        tach_periods(193, 1);
        chk("R3 no lock after first edge", int'(lock_n), 1);
        tach_periods(193, 3);
        chk("R2 locked at nominal", int'(lock_n), 0);

        // R5: too fast sets overspeed; slightly fast relocks but holds it
        tach_periods(170, 3);
        chk("R5 overspeed set", int'(overspeed), 1);
        chk("R2 unlocked when fast", int'(lock_n), 1);
        tach_periods(188, 3);
        chk("R5 overspeed held above nominal", int'(overspeed), 1);
        chk("R2 relocked in window", int'(lock_n), 0);
        tach_periods(196, 3);
        chk("R5 overspeed released below nominal", int'(overspeed), 0);
        tach_periods(220, 2);
        chk("R2 unlocked when slow", int'(lock_n), 1);

        // R6/R7: stall with tachometer stopped
        to_seen = 0;
        repeat (3000) @(negedge clk);
        chk("R6 force_up on missing pulses", int'(force_up), 1);
        chk("R7 exactly one time-out", to_seen, 1);

        // R8: stop clears the stall counter
        start_stop = 1'b1;
        repeat (50) @(negedge clk);
        start_stop = 1'b0;
        to_seen = 0;
        repeat (1200) @(negedge clk);
        chk("R8 no time-out before full count", to_seen, 0);
        repeat (200) @(negedge clk);
        chk("R8 time-out after full count", to_seen, 1);

        // R6/R3: restart after expiry
        tach_periods(193, 1);
        chk("R6 force_up cleared by transition", int'(force_up), 0);
        chk("R3 no lock on first edge after expiry", int'(lock_n), 1);
        tach_periods(193, 3);
        chk("R3 locked after restart", int'(lock_n), 0);

        // R1/R2: window edges with pre-divider 6
        cfg_div = 2'b10;
        tach_periods(366, 3);
        chk("R2 lower bound inclusive", int'(lock_n), 0);
        tach_periods(365, 2);
        chk("R2 just below lower bound", int'(lock_n), 1);
        chk("R5 just below lower bound", int'(overspeed), 1);
        tach_periods(404, 2);
        chk("R2 upper bound inclusive", int'(lock_n), 0);
        tach_periods(405, 2);
        chk("R2 just above upper bound", int'(lock_n), 1);

        // R1: doubled pre-divider 16
        cfg_div = 2'b11; freq_sel = 1'b0;
        tach_periods(1025, 3);
        chk("R1 nominal 16x base", int'(lock_n), 0);

        // R2: gated reference enable
        cfg_div = 2'b00; freq_sel = 1'b1; ref_half = 1;
        tach_periods(386, 4);
        chk("R2 lock with half-rate reference", int'(lock_n), 0);

        repeat (10) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule